// File: doc/BRIEF.md
# Round-Key Sequencer for AES-128/256

This block produces AES round keys one per round, in step with an iterative cipher datapath, for both directions. It holds three key stores: the initial key as written, a working full key that the expansion steps, and a saved decryption start key (the full key of the last encryption round). Forward operation steps the FIPS key schedule from the initial key. Backward operation steps the same recurrence in reverse from the saved start key. Only four S-boxes are used, and one step logic serves both directions.

The first decryption after a key change, or after a change of key length, begins with a precompute phase. During this phase the block runs a full forward expansion while the cipher waits. The final full key is captured, and the round keys are then issued from last to first. Later decryptions under the same key start at once, so the direction can be switched with no overhead. Encryption never needs the precompute.

An operation is launched by a `start_i`/`start_ready_o` handshake. The round keys then flow out on a valid/ready stream. Each accepted key advances the schedule by one round. While `rkey_ready_i` is low, the current key is held. There is no time limit on back-pressure.

Top module: `key_expander`

## Requirements
- R1: `key_len_i` = 0 selects a 128-bit key with 10 rounds, and 1 selects a 256-bit key with 14 rounds. Key word j (j = 0..7) is `key_i[255-32j -: 32]`, and a round key is output as its word 0 in bits 127:96 through word 3 in bits 31:0. An accepted encrypt start raises `rkey_valid_o` in the next cycle. The block then delivers round keys 0 through Nr of the standard schedule, one per handshake, with no busy phase. A 256-bit schedule alternates between a rotate-substitute-constant step and a substitute-only step.
- R2: While `rkey_valid_o` is high and `rkey_ready_i` is low, `rkey_o` and `rkey_valid_o` hold. The cycle after the final key (round Nr when encrypting, round 0 when decrypting) is accepted, `rkey_valid_o` is low and `start_ready_o` is high.
- R3: A decrypt start with no usable saved key holds `busy_o` high for exactly Nr cycles, with `rkey_valid_o` low. Round keys Nr down to 0 then follow.
- R4: A decrypt start with a usable saved key raises `rkey_valid_o` in the next cycle, without busy. Round keys Nr down to 0 follow.
- R5: `dec_key_valid_o` rises in the cycle `busy_o` falls at the end of a precompute. It clears after any key word write accepted while idle.
- R6: A saved key is usable only for the key length it was computed with. A decrypt start with the other length precomputes again.
- R7: Key word writes while not idle are ignored. They change neither the schedule of later operations nor `dec_key_valid_o`.
- R8: `start_ready_o` is high only when idle. A start while not idle is ignored and does not disturb the running sequence.
- R9: After reset, `start_ready_o` = 1 and `busy_o`, `rkey_valid_o` and `dec_key_valid_o` are 0. Exactly one of `start_ready_o`, `busy_o` and `rkey_valid_o` is high at any time.
- R10: With a 128-bit key, key words 4..7 have no effect on any round key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| key_i | input | 256 | Initial key words, word 0 in the top bits |
| key_we_i | input | 8 | Per-word write strobe for the initial key (taken only when idle) |
| key_len_i | input | 1 | 0: 128-bit key, 1: 256-bit key; sampled at start |
| decrypt_i | input | 1 | Direction for the next operation; sampled at start |
| start_i | input | 1 | Launch one schedule pass |
| start_ready_o | output | 1 | Idle, start accepted |
| busy_o | output | 1 | Decryption start key being precomputed |
| dec_key_valid_o | output | 1 | A saved decryption start key is held |
| rkey_valid_o | output | 1 | Round-key stream valid |
| rkey_ready_i | input | 1 | Round-key stream ready; a handshake advances one round |
| rkey_o | output | 128 | Current round key |

## Verification
A wrong working full key or round constant shows at the first stream handshake after the faulty step. From that point every later round key differs, so the final key of a pass exposes any error earlier in the pass. A corrupt saved key shows at once, because it is the first round key of every later decryption. A wrong round counter shows as a pass with one key too many or too few, seen as `rkey_valid_o` staying high or dropping one handshake early. A wrong saved-key flag shows as a precompute that appears or is missing in the busy-cycle count of the next decryption.

// File: rtl/kexp_pkg.sv
package kexp_pkg;

  typedef enum logic [1:0] {
    KX_IDLE = 2'd0,
    KX_PRE  = 2'd1,
    KX_RUN  = 2'd2
  } kx_state_e;

  localparam int WORD_W = 32;
  localparam int BYTE_PER_WORD = 4;

  // multiply by x in GF(2^8), reduction polynomial x^8+x^4+x^3+x+1
  function automatic logic [7:0] kx_xtime(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  // divide by x in GF(2^8)
  function automatic logic [7:0] kx_inv_xtime(input logic [7:0] a);
    return a[0] ? (((a ^ 8'h1b) >> 1) | 8'h80) : (a >> 1);
  endfunction

  function automatic logic [7:0] kx_gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p;
    logic [7:0] x;
    p = 8'h00;
    x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ x;
      x = kx_xtime(x);
    end
    return p;
  endfunction

  // multiplicative inverse as a^254 (maps 0 to 0)
  function automatic logic [7:0] kx_ginv(input logic [7:0] a);
    logic [7:0] e2, e3, e6, e12, e15, e30, e60, e120, e240, e252;
    e2   = kx_gmul(a, a);
    e3   = kx_gmul(e2, a);
    e6   = kx_gmul(e3, e3);
    e12  = kx_gmul(e6, e6);
    e15  = kx_gmul(e12, e3);
    e30  = kx_gmul(e15, e15);
    e60  = kx_gmul(e30, e30);
    e120 = kx_gmul(e60, e60);
    e240 = kx_gmul(e120, e120);
    e252 = kx_gmul(e240, e12);
    return kx_gmul(e252, e2);
  endfunction

  function automatic logic [7:0] kx_rotl8(input logic [7:0] b, input int k);
    logic [15:0] d;
    d = {b, b} << k;
    return d[15:8];
  endfunction

  function automatic logic [7:0] kx_sbox(input logic [7:0] a);
    logic [7:0] b;
    b = kx_ginv(a);
    return b ^ kx_rotl8(b, 1) ^ kx_rotl8(b, 2) ^ kx_rotl8(b, 3) ^ kx_rotl8(b, 4) ^ 8'h63;
  endfunction

  // round constant number n (n = 0 gives 01)
  function automatic logic [7:0] kx_rcon(input int n);
    logic [7:0] r;
    r = 8'h01;
    for (int i = 0; i < n; i++) r = kx_xtime(r);
    return r;
  endfunction

endpackage

// File: rtl/kexp_sbox.sv
module kexp_sbox
  import kexp_pkg::*;
(
  input  logic [7:0] in_i,
  output logic [7:0] out_o
);

  assign out_o = kx_sbox(in_i);

endmodule

// File: rtl/kexp_step.sv
// One schedule step, forward or backward, 128- or 256-bit window.
module kexp_step
  import kexp_pkg::*;
#(
  parameter int NW = 8,
  parameter int NB = 4
) (
  input  logic [NW-1:0][WORD_W-1:0] fk_i,
  input  logic                      long_i,
  input  logic                      inverse_i,
  input  logic                      use_rot_i,
  input  logic [7:0]                rcon_i,
  output logic [NW-1:0][WORD_W-1:0] nx_o
);

  logic [WORD_W-1:0]         sel_w;
  logic [WORD_W-1:0]         rot_w;
  logic [WORD_W-1:0]         sub_w;
  logic [WORD_W-1:0]         g_w;
  logic [WORD_W-1:0]         acc;
  logic [NB-1:0][WORD_W-1:0] fresh;
  logic [NB-1:0][WORD_W-1:0] back;

  // word fed to the S-boxes
  always_comb begin
    if (long_i) sel_w = inverse_i ? fk_i[NB-1] : fk_i[NW-1];
    else        sel_w = inverse_i ? (fk_i[NB-1] ^ fk_i[NB-2]) : fk_i[NB-1];
  end

  assign rot_w = use_rot_i ? {sel_w[WORD_W-9:0], sel_w[WORD_W-1:WORD_W-8]} : sel_w;

  for (genvar b = 0; b < BYTE_PER_WORD; b++) begin : g_sb
    kexp_sbox i_sb (
      .in_i (rot_w[8*b +: 8]),
      .out_o(sub_w[8*b +: 8])
    );
  end

  assign g_w = sub_w ^ (use_rot_i ? {rcon_i, {(WORD_W-8){1'b0}}} : '0);

  always_comb begin
    acc = g_w;
    for (int j = 0; j < NB; j++) begin
      acc      = acc ^ fk_i[j];
      fresh[j] = acc;
    end
    for (int j = 0; j < NB; j++) begin
      if (j == 0) back[j] = fk_i[long_i ? NB : 0] ^ g_w;
      else        back[j] = long_i ? (fk_i[NB+j] ^ fk_i[NB+j-1]) : (fk_i[j] ^ fk_i[j-1]);
    end
    nx_o = fk_i;
    for (int j = 0; j < NB; j++) begin
      if (!inverse_i) begin
        if (long_i) begin
          nx_o[j]    = fk_i[NB+j];
          nx_o[NB+j] = fresh[j];
        end else begin
          nx_o[j]    = fresh[j];
        end
      end else begin
        nx_o[j] = back[j];
        if (long_i) nx_o[NB+j] = fk_i[j];
      end
    end
  end

endmodule

// File: rtl/kexp_fsm.sv
module kexp_fsm
  import kexp_pkg::*;
#(
  parameter int RND_S = 10,
  parameter int RND_L = 14,
  parameter int CNT_W = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       decrypt_i,
  input  logic       key_len_i,
  input  logic       dec_ok_i,
  input  logic       rkey_ready_i,
  output logic       start_ready_o,
  output logic       busy_o,
  output logic       rkey_valid_o,
  output logic       load_init_o,
  output logic       load_dec_o,
  output logic       step_o,
  output logic       save_o,
  output logic       long_o,
  output logic       inv_o,
  output logic       use_rot_o,
  output logic [7:0] rcon_o
);

  localparam logic [7:0]       RCON_DEC_S = kx_rcon(RND_S - 1);
  localparam logic [7:0]       RCON_DEC_L = kx_rcon(RND_L / 2 - 1);
  localparam logic [CNT_W-1:0] NR_S = CNT_W'(RND_S);
  localparam logic [CNT_W-1:0] NR_L = CNT_W'(RND_L);

  kx_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [7:0]       rcon_q, rcon_d;
  logic             dir_q, dir_d;
  logic             len_q, len_d;
  logic [CNT_W-1:0] nr_q;
  logic             last_key;

  assign nr_q      = len_q ? NR_L : NR_S;
  assign long_o    = len_q;
  assign inv_o     = (state_q == KX_RUN) && dir_q;
  assign use_rot_o = !len_q || (inv_o ? cnt_q[0] : !cnt_q[0]);
  assign rcon_o    = rcon_q;
  assign last_key  = dir_q ? (cnt_q == '0) : (cnt_q == nr_q);

  assign start_ready_o = (state_q == KX_IDLE);
  assign busy_o        = (state_q == KX_PRE);
  assign rkey_valid_o  = (state_q == KX_RUN);

  always_comb begin
    state_d     = state_q;
    cnt_d       = cnt_q;
    rcon_d      = rcon_q;
    dir_d       = dir_q;
    len_d       = len_q;
    load_init_o = 1'b0;
    load_dec_o  = 1'b0;
    step_o      = 1'b0;
    save_o      = 1'b0;
    unique case (state_q)
      KX_IDLE: begin
        if (start_i) begin
          len_d = key_len_i;
          dir_d = decrypt_i;
          if (decrypt_i && dec_ok_i) begin
            load_dec_o = 1'b1;
            state_d    = KX_RUN;
            cnt_d      = key_len_i ? NR_L : NR_S;
            rcon_d     = key_len_i ? RCON_DEC_L : RCON_DEC_S;
          end else begin
            load_init_o = 1'b1;
            cnt_d       = '0;
            rcon_d      = 8'h01;
            state_d     = decrypt_i ? KX_PRE : KX_RUN;
          end
        end
      end
      KX_PRE: begin
        step_o = 1'b1;
        cnt_d  = cnt_q + CNT_W'(1);
        rcon_d = use_rot_o ? kx_xtime(rcon_q) : rcon_q;
        if (cnt_q == nr_q - CNT_W'(1)) begin
          save_o  = 1'b1;
          state_d = KX_RUN;
          rcon_d  = len_q ? RCON_DEC_L : RCON_DEC_S;
        end
      end
      KX_RUN: begin
        if (rkey_ready_i) begin
          if (last_key) begin
            state_d = KX_IDLE;
          end else begin
            step_o = 1'b1;
            cnt_d  = dir_q ? (cnt_q - CNT_W'(1)) : (cnt_q + CNT_W'(1));
            if (use_rot_o) rcon_d = dir_q ? kx_inv_xtime(rcon_q) : kx_xtime(rcon_q);
          end
        end
      end
      default: state_d = KX_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= KX_IDLE;
      cnt_q   <= '0;
      rcon_q  <= 8'h01;
      dir_q   <= 1'b0;
      len_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      rcon_q  <= rcon_d;
      dir_q   <= dir_d;
      len_q   <= len_d;
    end
  end

endmodule

// File: rtl/key_expander.sv
module key_expander
  import kexp_pkg::*;
#(
  parameter int KEY_W = 256,
  parameter int BLK_W = 128,
  parameter int RND_S = 10,
  parameter int RND_L = 14
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [KEY_W-1:0]         key_i,
  input  logic [KEY_W/WORD_W-1:0]  key_we_i,
  input  logic                     key_len_i,
  input  logic                     decrypt_i,
  input  logic                     start_i,
  output logic                     start_ready_o,
  output logic                     busy_o,
  output logic                     dec_key_valid_o,
  output logic                     rkey_valid_o,
  input  logic                     rkey_ready_i,
  output logic [BLK_W-1:0]         rkey_o
);

  localparam int NW    = KEY_W / WORD_W;
  localparam int NB    = BLK_W / WORD_W;
  localparam int CNT_W = $clog2(RND_L + 1);

  logic [NW-1:0][WORD_W-1:0] init_q, dec_q, fk_q, nx;
  logic       dec_valid_q, dec_len_q;
  logic       load_init, load_dec, step, save, long_sel, inv_sel, use_rot;
  logic [7:0] rcon;
  logic       dec_ok;
  logic       key_write;

  assign dec_ok    = dec_valid_q && (dec_len_q == key_len_i);
  assign key_write = start_ready_o && (|key_we_i);

  kexp_fsm #(
    .RND_S(RND_S),
    .RND_L(RND_L),
    .CNT_W(CNT_W)
  ) i_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .decrypt_i    (decrypt_i),
    .key_len_i    (key_len_i),
    .dec_ok_i     (dec_ok),
    .rkey_ready_i (rkey_ready_i),
    .start_ready_o(start_ready_o),
    .busy_o       (busy_o),
    .rkey_valid_o (rkey_valid_o),
    .load_init_o  (load_init),
    .load_dec_o   (load_dec),
    .step_o       (step),
    .save_o       (save),
    .long_o       (long_sel),
    .inv_o        (inv_sel),
    .use_rot_o    (use_rot),
    .rcon_o       (rcon)
  );

  kexp_step #(
    .NW(NW),
    .NB(NB)
  ) i_step (
    .fk_i     (fk_q),
    .long_i   (long_sel),
    .inverse_i(inv_sel),
    .use_rot_i(use_rot),
    .rcon_i   (rcon),
    .nx_o     (nx)
  );

  // initial key store, writable only while idle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_q <= '0;
    end else if (start_ready_o) begin
      for (int j = 0; j < NW; j++) begin
        if (key_we_i[j]) init_q[j] <= key_i[KEY_W-1-WORD_W*j -: WORD_W];
      end
    end
  end

  // working full key
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        fk_q <= '0;
    else if (load_init) fk_q <= init_q;
    else if (load_dec)  fk_q <= dec_q;
    else if (step)      fk_q <= nx;
  end

  // saved decryption start key and its qualifiers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dec_q       <= '0;
      dec_valid_q <= 1'b0;
      dec_len_q   <= 1'b0;
    end else begin
      if (save) begin
        dec_q     <= nx;
        dec_len_q <= long_sel;
      end
      if (key_write)  dec_valid_q <= 1'b0;
      else if (save)  dec_valid_q <= 1'b1;
    end
  end

  assign dec_key_valid_o = dec_valid_q;

  always_comb begin
    for (int j = 0; j < NB; j++) rkey_o[BLK_W-1-WORD_W*j -: WORD_W] = fk_q[j];
  end

endmodule

// File: rtl/key_expander_chk.sv
module key_expander_chk #(
  parameter int BLK_W = 128,
  parameter int NW    = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [NW-1:0]    key_we_i,
  input logic             decrypt_i,
  input logic             start_i,
  input logic             start_ready_o,
  input logic             busy_o,
  input logic             dec_key_valid_o,
  input logic             rkey_valid_o,
  input logic             rkey_ready_i,
  input logic [BLK_W-1:0] rkey_o
);

  a_r2_hold_under_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rkey_valid_o && !rkey_ready_i |=> rkey_valid_o && $stable(rkey_o));

  a_r1_encrypt_no_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && start_ready_o && !decrypt_i |=> rkey_valid_o && !busy_o);

  a_r3_precompute_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && start_ready_o && decrypt_i && !dec_key_valid_o |=> busy_o);

  a_r3_quiet_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !rkey_valid_o);

  a_r5_clear_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_ready_o && (|key_we_i) |=> !dec_key_valid_o);

  a_r5_set_with_busy_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dec_key_valid_o) |-> $fell(busy_o));

  a_r7_keep_while_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_ready_o && dec_key_valid_o |=> dec_key_valid_o);

  a_r9_one_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({start_ready_o, busy_o, rkey_valid_o}) == 1);

endmodule

bind key_expander key_expander_chk #(
  .BLK_W(BLK_W),
  .NW   (NW)
) i_key_expander_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .key_we_i       (key_we_i),
  .decrypt_i      (decrypt_i),
  .start_i        (start_i),
  .start_ready_o  (start_ready_o),
  .busy_o         (busy_o),
  .dec_key_valid_o(dec_key_valid_o),
  .rkey_valid_o   (rkey_valid_o),
  .rkey_ready_i   (rkey_ready_i),
  .rkey_o         (rkey_o)
);

// File: tb/test_key_expander.sv
`timescale 1ns/1ps
module test_key_expander;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [255:0] key_i = '0;
  logic [7:0]   key_we = '0;
  logic         key_len = 1'b0;
  logic         decrypt = 1'b0;
  logic         start = 1'b0;
  logic         rkey_ready = 1'b0;
  logic         start_ready, busy, dec_valid, rkey_valid;
  logic [127:0] rkey;

  always #4 clk = ~clk;

  key_expander i_key_expander (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .key_i          (key_i),
    .key_we_i       (key_we),
    .key_len_i      (key_len),
    .decrypt_i      (decrypt),
    .start_i        (start),
    .start_ready_o  (start_ready),
    .busy_o         (busy),
    .dec_key_valid_o(dec_valid),
    .rkey_valid_o   (rkey_valid),
    .rkey_ready_i   (rkey_ready),
    .rkey_o         (rkey)
  );

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0]   sb_t [256];
  logic [127:0] exp_rk [15];
  logic [127:0] last_seen;

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  function automatic logic [7:0] tb_xt(input logic [7:0] a);
    return a[7] ? ((a << 1) ^ 8'h1b) : (a << 1);
  endfunction

  function automatic logic [7:0] tb_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r = 0;
    logic [7:0] x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) r ^= x;
      x = tb_xt(x);
    end
    return r;
  endfunction

  task automatic init_sbox();
    for (int x = 0; x < 256; x++) begin
      logic [7:0] inv = 0;
      logic [7:0] s;
      for (int y = 1; y < 256; y++) if (tb_mul(8'(x), 8'(y)) == 8'h01) inv = 8'(y);
      for (int i = 0; i < 8; i++)
        s[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8] ^ (8'h63 >> i) & 1'b1;
      sb_t[x] = s;
    end
  endtask

  function automatic logic [31:0] tb_sub(input logic [31:0] w);
    return {sb_t[w[31:24]], sb_t[w[23:16]], sb_t[w[15:8]], sb_t[w[7:0]]};
  endfunction

  // reference schedule straight from the recurrence, word i = W[i]
  task automatic build_exp(input logic [255:0] k, input bit len);
    logic [31:0] w [60];
    int nk = len ? 8 : 4;
    int nr = len ? 14 : 10;
    logic [7:0] rc = 8'h01;
    for (int i = 0; i < nk; i++) w[i] = k[255-32*i -: 32];
    for (int i = nk; i < 4*(nr+1); i++) begin
      logic [31:0] t = w[i-1];
      if (i % nk == 0) begin
        t = tb_sub({t[23:0], t[31:24]}) ^ {rc, 24'h0};
        rc = tb_xt(rc);
      end else if (nk == 8 && i % 8 == 4) begin
        t = tb_sub(t);
      end
      w[i] = w[i-nk] ^ t;
    end
    for (int r = 0; r <= nr; r++) exp_rk[r] = {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]};
  endtask

  task automatic write_key(input logic [255:0] k);
    @(negedge clk);
    key_i = k;
    key_we = 8'hff;
    @(negedge clk);
    key_we = 8'h00;
  endtask

  task automatic do_op(input bit dec, input bit len, input bit exp_pre, input int seed,
                       input bit poke, input string req);
    int nr = len ? 14 : 10;
    @(negedge clk);
    chk(start_ready == 1'b1, {req, " R8 idle before start"}, 128'(start_ready), 128'd1);
    start = 1'b1;
    decrypt = dec;
    key_len = len;
    @(negedge clk);
    start = 1'b0;
    if (exp_pre) begin
      int cnt = 0;
      bit quiet = 1'b1;
      while (busy && cnt < 40) begin
        if (rkey_valid || start_ready) quiet = 1'b0;
        cnt++;
        @(negedge clk);
      end
      chk(cnt == nr, {req, " R3 precompute cycles"}, 128'(cnt), 128'(nr));
      chk(quiet, {req, " R3 no key during precompute"}, 128'(quiet), 128'd1);
    end else begin
      chk(!busy && rkey_valid, {req, " R1/R4 no precompute"}, {busy, rkey_valid}, 128'b01);
    end
    for (int idx = 0; idx <= nr; idx++) begin
      logic [127:0] e = dec ? exp_rk[nr-idx] : exp_rk[idx];
      int stall = (seed * 7 + idx * 3) % 4;
      if (poke && idx == 1 && stall == 0) stall = 1;
      for (int k = 0; k < stall; k++) begin
        logic [255:0] kk = key_i;
        rkey_ready = 1'b0;
        if (poke && idx == 1 && k == 0) begin
          key_i = ~kk;
          key_we = 8'hff;
          start = 1'b1;
          decrypt = ~dec;
        end
        chk(rkey_valid && rkey == e, {req, " R2 held under stall"}, rkey, e);
        @(negedge clk);
        if (poke && idx == 1 && k == 0) begin
          key_i = kk;
          key_we = 8'h00;
          start = 1'b0;
          decrypt = dec;
        end
      end
      rkey_ready = 1'b1;
      chk(rkey_valid && rkey == e, {req, " round key"}, rkey, e);
      last_seen = rkey;
      @(negedge clk);
      rkey_ready = 1'b0;
    end
    chk(!rkey_valid && start_ready, {req, " R2 end of pass"}, {rkey_valid, start_ready}, 128'b01);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [255:0] k;
    init_sbox();
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(start_ready && !busy && !rkey_valid && !dec_valid, "R9 reset outputs",
        {start_ready, busy, rkey_valid, dec_valid}, 128'b1000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(start_ready && !busy && !rkey_valid && !dec_valid, "R9 after release",
        {start_ready, busy, rkey_valid, dec_valid}, 128'b1000);

    // 128-bit known schedule, upper words are junk (R10)
    k = {128'h000102030405060708090a0b0c0d0e0f, 128'hdeadbeef_0badf00d_12345678_cafef00d};
    write_key(k);
    build_exp(k, 1'b0);
    do_op(1'b0, 1'b0, 1'b0, 1, 1'b0, "R1 enc128");
    chk(last_seen == 128'h13111d7fe3944a17f307a78b4d2b30c5, "R1 last 128 key", last_seen,
        128'h13111d7fe3944a17f307a78b4d2b30c5);
    chk(!dec_valid, "R5 no saved key yet", 128'(dec_valid), 128'd0);
    do_op(1'b1, 1'b0, 1'b1, 2, 1'b0, "R3 dec128 first");
    chk(dec_valid, "R5 saved after precompute", 128'(dec_valid), 128'd1);
    chk(last_seen == 128'h000102030405060708090a0b0c0d0e0f, "R3 dec ends at initial key", last_seen,
        128'h000102030405060708090a0b0c0d0e0f);
    do_op(1'b1, 1'b0, 1'b0, 3, 1'b0, "R4 dec128 saved");
    do_op(1'b0, 1'b0, 1'b0, 0, 1'b1, "R7 R8 enc128 with pokes");
    chk(dec_valid, "R7 saved flag kept", 128'(dec_valid), 128'd1);
    do_op(1'b0, 1'b0, 1'b0, 5, 1'b0, "R7 key unchanged");
    do_op(1'b1, 1'b0, 1'b0, 6, 1'b0, "R7 saved key unchanged");
    build_exp(k, 1'b1);
    do_op(1'b1, 1'b1, 1'b1, 7, 1'b0, "R6 dec256 after 128 save");
    build_exp(k, 1'b0);
    do_op(1'b1, 1'b0, 1'b1, 8, 1'b0, "R6 dec128 after 256 save");
    k[127:0] = ~k[127:0];
    write_key(k);
    @(negedge clk);
    chk(!dec_valid, "R5 cleared by key write", 128'(dec_valid), 128'd0);
    do_op(1'b1, 1'b0, 1'b1, 9, 1'b0, "R10 dec128 new junk words");

    // 256-bit known schedule
    k = 256'h000102030405060708090a0b0c0d0e0f101112131415161718191a1b1c1d1e1f;
    write_key(k);
    build_exp(k, 1'b1);
    do_op(1'b0, 1'b1, 1'b0, 1, 1'b0, "R1 enc256");
    chk(last_seen == 128'h24fc79ccbf0979e9371ac23c6d68de36, "R1 last 256 key", last_seen,
        128'h24fc79ccbf0979e9371ac23c6d68de36);
    do_op(1'b1, 1'b1, 1'b1, 2, 1'b0, "R3 dec256 first");
    do_op(1'b1, 1'b1, 1'b0, 3, 1'b0, "R4 dec256 saved");

    // sweep of keys, both lengths, stall patterns
    for (int t = 0; t < 24; t++) begin
      bit len = t[0];
      for (int j = 0; j < 8; j++)
        k[255-32*j -: 32] = (32'(t + 1) * 32'h9e3779b9) ^ (32'(j) * 32'h7f4a7c15) ^ 32'h5bd1e995;
      write_key(k);
      @(negedge clk);
      chk(!dec_valid, "R5 sweep clear", 128'(dec_valid), 128'd0);
      build_exp(k, len);
      do_op(1'b0, len, 1'b0, t, 1'b0, "R1 sweep enc");
      do_op(1'b1, len, 1'b1, t + 1, 1'b0, "R3 sweep dec");
      do_op(1'b0, len, 1'b0, t + 2, 1'b0, "R1 sweep enc again");
      do_op(1'b1, len, 1'b0, t + 3, 1'b0, "R4 sweep dec saved");
    end

    summary();
    $finish;
  end

endmodule